// File: doc/BRIEF.md
# TDM Serial Input Framer

This block is the receive front end of a time-slot switch. It takes eight serial time-division-multiplexed input lanes that share one frame. Each lane runs at 2048 kbit/s. A frame lasts 125 us and holds 32 channels of 8 bits each, so it is 256 bit cells long. The block turns every channel of every lane into a parallel byte and hands the bytes to a 256x8 data memory as a stream of writes. The stream carries a write address and a data byte.

Timing comes from a clock that runs at twice the bit rate, so each bit cell lasts exactly two clock cycles. An active-low frame-sync input forces the position counter back to the start of the frame. Without a sync pulse the counter simply wraps. The current channel, bit and half-cell position is brought out so that other parts of the switch can stay aligned with the frame.

Each memory write is a valid/ready transfer. The sink may hold `wr_ready` low to apply back-pressure, and the offered address and byte stay frozen while it does. The bytes of one channel must all be accepted before the next channel completes, which takes 16 cycles. A channel that completes while some bytes of the previous channel are still undelivered replaces them, and those stale bytes are never written.

Top module: `tdm_serial_framer`

## Requirements
- R1: A 9-bit position, made up of channel[4:0], bit[2:0] and half, advances by one on every clock in which frame_n was high. It wraps from 511 to 0 when no sync pulse arrives. It is visible on `frm_chan`, `frm_bit` and `frm_half`.
- R2: When `frame_n` is low at a clock edge, the position reads 0 in the following cycle.
- R3: Every lane is sampled once per bit cell, at the clock edge that ends the cell's first cycle (the cycle with half = 0). The value in the second cycle is ignored. Bit 0 of a channel is the first bit received and lands in the byte's most significant bit.
- R4: The byte received on lane s in channel c is written to address {s[2:0], c[4:0]}, so the lane number forms the upper three address bits.
- R5: `wr_valid` rises in the cycle right after the edge that samples the last bit of a channel (the cycle with bit 7, half 1). Within one channel, the lanes are offered in ascending order, starting with lane 0.
- R6: With `wr_ready` held high, each channel produces exactly eight writes in eight consecutive cycles. `wr_valid` is then low for the remaining eight cycles of that channel's period. When back-pressure still leaves at least eight ready cycles per channel period, all eight writes are still delivered.
- R7: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` stay unchanged in the next cycle, unless a new channel completes at that edge.
- R8: When a channel completes, all eight new bytes replace any bytes that have not yet been accepted. The next accepted write is then lane 0 of the newest channel.
- R9: During reset, `wr_valid` is low and the position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-bit-rate clock (two cycles per bit cell) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame sync; a low level restarts the position at the next edge |
| sdi | input | 8 | One serial data bit per input lane |
| wr_ready | input | 1 | Memory sink accepts the offered write |
| wr_valid | output | 1 | A write is offered |
| wr_addr | output | 8 | Memory address {lane, channel} |
| wr_data | output | 8 | Received channel byte |
| frm_chan | output | 5 | Current channel position in the frame |
| frm_bit | output | 3 | Current bit position in the channel |
| frm_half | output | 1 | Current half of the bit cell |

## Verification
A position counter that has lost step shows up at once on `frm_chan`, `frm_bit` and `frm_half`. It also moves the write bursts away from their expected cycles, so the first burst after the fault arrives one or more cycles early or late. A fault in sampling or shifting surfaces in the next write burst, at most 16 cycles later, as a wrong byte at a correct address: the input lanes carry inverted bits in the second half of every cell, and the bytes change with the lane, the channel and the frame. A fault in the drain logic surfaces as addresses out of order, a missing or extra write in a channel period, or an offer that changes while it is stalled. All of these are visible within the channel period in which they occur.

// File: rtl/tdm_pkg.sv
`timescale 1ns/1ps
package tdm_pkg;
  // Default geometry of one frame
  localparam int unsigned LANES_DEF  = 8;
  localparam int unsigned CHANS_DEF  = 32;
  localparam int unsigned BITS_DEF   = 8;
endpackage

// File: rtl/tdm_frame_counter.sv
`timescale 1ns/1ps
module tdm_frame_counter #(
  parameter int unsigned CHANS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned CH_W  = $clog2(CHANS),
  localparam int unsigned BIT_W = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  output logic [CH_W-1:0]  chan_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             half_o,
  output logic             shift_o,
  output logic             cap_o
);
  localparam int unsigned POS_W = CH_W + BIT_W + 1;

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pos_q <= '0;
    else if (!frame_n) pos_q <= '0;
    else               pos_q <= pos_q + 1'b1;
  end

  assign half_o  = pos_q[0];
  assign bit_o   = pos_q[BIT_W:1];
  assign chan_o  = pos_q[POS_W-1:BIT_W+1];
  // mid-cell sample: edge that closes the first half of a cell
  assign shift_o = ~pos_q[0];
  assign cap_o   = shift_o && (bit_o == BIT_W'(BITS-1));

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n |=> pos_q == POS_W'($past(pos_q) + 1'b1));

  p_sync_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_n |=> pos_q == '0);

  p_cap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> !cap_o);
endmodule

// File: rtl/tdm_lane_shifter.sv
`timescale 1ns/1ps
module tdm_lane_shifter #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_i,
  input  logic            sdi_i,
  output logic [BITS-1:0] byte_o
);
  logic [BITS-2:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (shift_i) sh_q <= {sh_q[BITS-3:0], sdi_i};
  end

  // complete byte as seen at the sampling edge of the last bit
  assign byte_o = {sh_q, sdi_i};
endmodule

// File: rtl/tdm_write_drain.sv
`timescale 1ns/1ps
module tdm_write_drain #(
  parameter int unsigned LANES = 8,
  parameter int unsigned CHANS = 32,
  parameter int unsigned BITS  = 8,
  localparam int unsigned LN_W   = $clog2(LANES),
  localparam int unsigned CH_W   = $clog2(CHANS),
  localparam int unsigned ADDR_W = LN_W + CH_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_i,
  input  logic [CH_W-1:0]       cap_chan_i,
  input  logic [LANES*BITS-1:0] bytes_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [BITS-1:0]       data_o
);
  logic [LANES-1:0]           pend_q;
  logic [LANES-1:0][BITS-1:0] snap_q;
  logic [CH_W-1:0]            chan_q;
  logic [LN_W-1:0]            sel;
  logic                       found;
  logic                       take;

  // lowest pending lane goes first
  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < int'(LANES); i++) begin
      if (pend_q[i] && !found) begin
        sel   = LN_W'(i);
        found = 1'b1;
      end
    end
  end

  assign valid_o = |pend_q;
  assign data_o  = snap_q[sel];
  assign addr_o  = {sel, chan_q};
  assign take    = valid_o && ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      snap_q <= '0;
      chan_q <= '0;
    end else if (cap_i) begin
      pend_q <= '1;
      snap_q <= bytes_i;
      chan_q <= cap_chan_i;
    end else if (take) begin
      pend_q[sel] <= 1'b0;
    end
  end

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i && !cap_i) |=> (valid_o && $stable(addr_o) && $stable(data_o)));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (pend_q == '1) && (chan_q == $past(cap_chan_i)));

  p_lane_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap_i) |=> (!valid_o || (sel > $past(sel))));

  p_one_per_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !cap_i) |=> ($countones(pend_q) + 1 == $countones($past(pend_q))));
endmodule

// File: rtl/tdm_serial_framer.sv
`timescale 1ns/1ps
module tdm_serial_framer
  import tdm_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned CHANS = CHANS_DEF,
  parameter int unsigned BITS  = BITS_DEF,
  localparam int unsigned LN_W   = $clog2(LANES),
  localparam int unsigned CH_W   = $clog2(CHANS),
  localparam int unsigned BIT_W  = $clog2(BITS),
  localparam int unsigned ADDR_W = LN_W + CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [LANES-1:0]  sdi,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BITS-1:0]   wr_data,
  output logic [CH_W-1:0]   frm_chan,
  output logic [BIT_W-1:0]  frm_bit,
  output logic              frm_half
);
  logic                  shift_en;
  logic                  cap_en;
  logic [LANES*BITS-1:0] lane_bytes;

  tdm_frame_counter #(.CHANS(CHANS), .BITS(BITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .chan_o  (frm_chan),
    .bit_o   (frm_bit),
    .half_o  (frm_half),
    .shift_o (shift_en),
    .cap_o   (cap_en)
  );

  for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
    tdm_lane_shifter #(.BITS(BITS)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_i (shift_en),
      .sdi_i   (sdi[g]),
      .byte_o  (lane_bytes[g*BITS +: BITS])
    );
  end

  tdm_write_drain #(.LANES(LANES), .CHANS(CHANS), .BITS(BITS)) u_drain (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_i      (cap_en),
    .cap_chan_i (frm_chan),
    .bytes_i    (lane_bytes),
    .ready_i    (wr_ready),
    .valid_o    (wr_valid),
    .addr_o     (wr_addr),
    .data_o     (wr_data)
  );

  p_burst_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (wr_valid && wr_addr[ADDR_W-1:CH_W] == '0));

  p_reset_idle_r9: assert property (@(posedge clk)
    !rst_n |-> !wr_valid);
endmodule

// File: tb/tdm_serial_framer_tb_top.sv
`timescale 1ns/1ps
module tdm_serial_framer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_n = 1'b1;
  logic [7:0] sdi = '0;
  logic       wr_ready = 1'b1;
  logic       wr_valid;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] frm_chan;
  logic [2:0] frm_bit;
  logic       frm_half;

  int total = 0;
  int fails = 0;
  int kb = 0;          // model position 0..511
  int fr = 0;          // model frame index
  int sync_cnt = 0;
  int mode = 0;        // 0 ready high, 1 patterned ready, 2 ready low
  bit done = 1'b0;

  always #4 clk = ~clk;

  tdm_serial_framer dut_i (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sdi(sdi),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .frm_chan(frm_chan), .frm_bit(frm_bit),
    .frm_half(frm_half)
  );

  function automatic logic [7:0] pat(int s, int ch, int f);
    return 8'((s * 29) + (ch * 7) + (f * 53) + 90);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (pos=%0d)", req, act, exp, kb);
    end
  endtask

  // reference frame position from the stated counting rules
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) kb <= 0;
    else if (!frame_n) begin
      kb <= 0; fr <= fr + 1; sync_cnt <= sync_cnt + 1;
    end else begin
      kb <= (kb + 1) % 512;
      if (kb == 511) fr <= fr + 1;
    end
  end

  int cyc = 0, settle = 0, sync_seen = 0, prev_mode = 0, wcnt = 0;
  int ov_chan = 0;
  bit ov_pend = 1'b0, hold_pend = 1'b0;
  logic [7:0] haddr, hdata;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (sync_seen != sync_cnt || mode != prev_mode) settle = 0;
      else settle++;
      sync_seen = sync_cnt;
      if (prev_mode == 2 && mode != 2) begin
        ov_pend = 1'b1;
        ov_chan = ((kb >> 4) + 31) & 31;
      end
      prev_mode = mode;
      case (mode)
        0: wr_ready = 1'b1;
        1: wr_ready = (cyc % 3) != 0;
        default: wr_ready = 1'b0;
      endcase
      // R3: second half of every cell carries the inverted bit
      for (int s = 0; s < 8; s++) begin
        logic [7:0] bv;
        logic b;
        bv = pat(s, kb >> 4, fr);
        b = bv[7 - ((kb >> 1) & 7)];
        sdi[s] = (kb % 2 == 1) ? ~b : b;
      end

      // R1: position outputs follow the model counter
      check({frm_chan, frm_bit, frm_half} == 9'(kb), "R1 position",
            {frm_chan, frm_bit, frm_half}, kb);

      // R6: burst size per channel period
      if (kb % 16 == 15) begin
        if (mode != 2 && settle >= 32)
          check(wcnt == 8, "R6 writes per channel", wcnt, 8);
        wcnt = 0;
      end

      // R7: stalled offer must hold unless a new channel just completed
      if (hold_pend && (kb % 16) != 15)
        check(wr_valid && wr_addr == haddr && wr_data == hdata, "R7 stall hold",
              {wr_valid, wr_addr, wr_data}, {1'b1, haddr, hdata});
      hold_pend = wr_valid && !wr_ready;
      haddr = wr_addr;
      hdata = wr_data;

      // R5/R6: exact cycle placement of the burst with ready high
      if (mode == 0 && settle >= 32) begin
        int ph;
        ph = (kb + 1) % 16;
        if (ph < 8)
          check(wr_valid && wr_addr == {3'(ph), 5'(((kb + 1) >> 4) - 1)},
                "R5 burst slot", {wr_valid, wr_addr},
                {1'b1, 3'(ph), 5'(((kb + 1) >> 4) - 1)});
        else
          check(!wr_valid, "R6 idle slot", wr_valid, 0);
      end

      if (wr_valid && wr_ready) begin
        int ch, s, f;
        ch = int'(wr_addr[4:0]);
        s  = int'(wr_addr[7:5]);
        f  = (ch == 31 && kb < 16) ? fr - 1 : fr;
        // R3, R4: byte matches lane/channel selected by the address
        check(wr_data == pat(s, ch, f), "R3,R4 data at address",
              wr_data, pat(s, ch, f));
        if (ov_pend) begin
          check(wr_addr == {3'd0, 5'(ov_chan)}, "R8 newest channel first",
                wr_addr, {3'd0, 5'(ov_chan)});
          ov_pend = 1'b0;
        end
        wcnt++;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!wr_valid, "R9 valid in reset", wr_valid, 0);
    check({frm_chan, frm_bit, frm_half} == 9'd0, "R9 position in reset",
          {frm_chan, frm_bit, frm_half}, 0);
    rst_n = 1'b1;
    // free run across a wrap with no sync pulse
    repeat (700) @(posedge clk);
    do @(negedge clk); while (kb != 200);
    frame_n = 1'b0;
    @(negedge clk);
    frame_n = 1'b1;
    // R2: position restarts after the sync pulse
    check({frm_chan, frm_bit, frm_half} == 9'd0, "R2 sync restart",
          {frm_chan, frm_bit, frm_half}, 0);
    repeat (1200) @(posedge clk);
    mode = 1;
    repeat (1300) @(posedge clk);
    mode = 2;
    repeat (40) @(posedge clk);
    do @(negedge clk); while (kb % 16 != 3);
    @(posedge clk);
    mode = 0;
    repeat (700) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    check(!ov_pend, "R8 write after overrun", ov_pend, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1600000;
    done = 1'b1;
    total++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule